// File: doc/BRIEF.md
# SD Command Line Engine

This block issues one SD command at a time on the bidirectional CMD line and collects the card's answer. The caller presents a 6-bit command index, a 32-bit argument and a response mode, then pulses `cmd_start`. The engine builds a 48-bit frame and clocks it out. The frame holds a start bit of 0, a transmission bit of 1, the index, the argument with its most significant bit first, a CRC7 and an end bit of 1. The engine then releases the line and, depending on the mode, waits for a 48-bit or 136-bit response.

The card clock is generated elsewhere. The engine runs on the system clock and follows two one-cycle strobes, `clk_rise` and `clk_fall`, that mark the card clock edges. CMD is driven on fall strobes and sampled on rise strobes. In the busy mode the engine also watches DAT0 after the response and reports completion only once the card releases it.

Every command ends with a one-cycle `cmd_done` pulse. A missing start bit raises `err_timeout`. A bad CRC or a bad frame raises `err_crc`. After either error the engine stays halted until `err_clr` is asserted.

States: IDLE (ready), SEND (frame going out), WAIT (line released, hunting for a start bit), RECV (shifting in response bits), CHECK (one cycle of framing and CRC evaluation), BUSY (waiting for DAT0 high), DONE (success pulse), FAIL (error pulse), HALT (held until cleared).

Transitions:
- IDLE→SEND on start.
- SEND→DONE when the frame is out in a no-response mode.
- SEND→WAIT when the frame is out in any other mode.
- WAIT→RECV on a start bit.
- WAIT→FAIL on timeout.
- RECV→CHECK on the last bit.
- CHECK→FAIL on a bad response.
- CHECK→BUSY in the busy mode.
- CHECK→DONE otherwise.
- BUSY→DONE when DAT0 is sampled high.
- DONE→IDLE.
- FAIL→HALT.
- HALT→IDLE on `err_clr`.

Top module: `sdcmd_engine`

## Requirements
- R1: The transmitted frame is 48 bits, first bit first: 0, 1, six index bits, the 32 argument bits most significant first, a CRC7 (polynomial x^7+x^3+1, register cleared to zero) computed over the preceding 40 bits, and a final 1. Index 0 with argument 0 therefore gives the frame 0x400000000095.
- R2: `cmd_out` changes only at clock edges where `clk_fall` is high. `cmd_oe` is high from start until the frame is out and low otherwise. `cmd_out` rests at 1 while idle.
- R3: `rsp_mode` encoding is 0 = no response, 1 = 48-bit with CRC check, 2 = 48-bit with the CRC ignored, 3 = 136-bit with CRC check, 4 = 48-bit with CRC check followed by a busy wait. Codes 5 to 7 act as 0. In a no-response mode `cmd_done` follows the frame with no error and no waiting for the line.
- R4: After a 48-bit response, `rsp_w0` holds response bits 39..8 (the 32 bits after the start, transmission and six index bits), and `rsp_w1` to `rsp_w3` read zero.
- R5: After a 136-bit response, {`rsp_w0`,`rsp_w1`,`rsp_w2`,`rsp_w3`} holds response bits 127..0, so the most significant word comes first. The CRC7 of a long response covers its bits 127..8, the 120 bits after the leading eight.
- R6: In modes 1, 3 and 4, a received CRC7 (response bits 7..1) that disagrees with the computed value raises `err_crc`. Mode 2 ignores the CRC field.
- R7: In every response mode, a transmission bit of 1 or an end bit of 0 raises `err_crc`.
- R8: The response start bit must be sampled within 64 rise strobes after the line is released. A start bit at the 64th rise is accepted. No start bit by then raises `err_timeout`.
- R9: In mode 4, after a good response `cmd_done` does not pulse until DAT0 has been sampled high on a rise strobe.
- R10: `cmd_done` is a one-cycle pulse at the end of every command, success or failure. An error flag rises in the same cycle as that pulse, and the two error flags are never high together.
- R11: While an error flag is set, `cmd_start` is ignored and no frame is driven. `err_clr` drops both flags. A start in the same cycle as `err_clr` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_rise | input | 1 | Strobe marking a rising card clock edge |
| clk_fall | input | 1 | Strobe marking a falling card clock edge |
| cmd_start | input | 1 | Begin a command (sampled in IDLE) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_mode | input | 3 | Response mode code |
| err_clr | input | 1 | Clear error flags and leave HALT |
| cmd_in | input | 1 | CMD line as seen from the card side |
| cmd_out | output | 1 | Value driven onto CMD |
| cmd_oe | output | 1 | CMD output enable |
| dat0_in | input | 1 | DAT0 line level, low while the card is busy |
| cmd_done | output | 1 | End-of-command pulse |
| err_timeout | output | 1 | No response start bit in time |
| err_crc | output | 1 | Response CRC or framing error |
| rsp_w0 | output | 32 | Response word 0 (most significant) |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 (least significant) |

## Verification
The start-bit detector and the timeout counter both act on the same rise strobe when the card answers on the very last allowed edge. The bench provokes this by holding CMD high for exactly 63 rises and then giving the start bit, expecting a clean response, and repeating with 64 idle rises, expecting only `err_timeout`. A second collision, `err_clr` and `cmd_start` in one cycle, is judged by the flags dropping while `cmd_oe` stays low. Only a later start may send a frame.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int SHORT_W  = 48;
    localparam int LONG_W   = 136;
    localparam int HDR_W    = 8;
    localparam int FRAME_W  = 48;
    localparam int BODY_W   = FRAME_W - 8;
    localparam int CNT_W    = $clog2(LONG_W + 1);

    typedef enum logic [2:0] {
        RSP_NONE        = 3'd0,
        RSP_SHORT       = 3'd1,
        RSP_SHORT_NOCRC = 3'd2,
        RSP_LONG        = 3'd3,
        RSP_SHORT_BUSY  = 3'd4
    } rsp_mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_RECV,
        S_CHECK,
        S_BUSY,
        S_DONE,
        S_FAIL,
        S_HALT
    } eng_state_e;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_body(input logic [BODY_W-1:0] v);
        logic [6:0] c;
        c = 7'd0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            c = crc7_step(c, v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               active_i,
    input  logic               fall_i,
    output logic               cmd_out_o,
    output logic               cmd_oe_o,
    output logic               sent_all_o
);

    localparam int TX_CNT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0]  sr_q;
    logic [TX_CNT_W-1:0] cnt_q;

    assign sent_all_o = (cnt_q == TX_CNT_W'(FRAME_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q      <= '0;
            cnt_q     <= '0;
            cmd_out_o <= 1'b1;
            cmd_oe_o  <= 1'b0;
        end else if (load_i) begin
            sr_q     <= frame_i;
            cnt_q    <= '0;
            cmd_oe_o <= 1'b1;
        end else if (active_i && fall_i) begin
            if (!sent_all_o) begin
                cmd_out_o <= sr_q[FRAME_W-1];
                sr_q      <= {sr_q[FRAME_W-2:0], 1'b0};
                cnt_q     <= cnt_q + 1'b1;
            end else begin
                cmd_out_o <= 1'b1;
                cmd_oe_o  <= 1'b0;
            end
        end
    end

    assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(cmd_out_o));

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_RISES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              wait_i,
    input  logic              recv_i,
    input  logic              rise_i,
    input  logic              cmd_i,
    input  logic              long_i,
    output logic              start_seen_o,
    output logic              timeout_o,
    output logic              last_bit_o,
    output logic [LONG_W-1:0] sr_o,
    output logic [6:0]        crc_o
);

    localparam int TO_W = $clog2(TIMEOUT_RISES + 1);

    logic [TO_W-1:0]  to_cnt_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [CNT_W-1:0] total_bits;
    logic             in_window;

    assign total_bits   = long_i ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
    assign in_window    = long_i ? (bit_cnt_q >= CNT_W'(HDR_W) && bit_cnt_q < CNT_W'(LONG_W - 8))
                                 : (bit_cnt_q < CNT_W'(SHORT_W - 8));
    assign start_seen_o = wait_i && rise_i && !cmd_i;
    assign timeout_o    = wait_i && rise_i && cmd_i && (to_cnt_q == TO_W'(TIMEOUT_RISES - 1));
    assign last_bit_o   = recv_i && rise_i && (bit_cnt_q == total_bits - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_cnt_q  <= '0;
            bit_cnt_q <= '0;
            sr_o      <= '0;
            crc_o     <= '0;
        end else if (arm_i) begin
            to_cnt_q  <= '0;
            bit_cnt_q <= '0;
            crc_o     <= '0;
        end else if (wait_i && rise_i) begin
            if (!cmd_i) begin
                sr_o      <= {sr_o[LONG_W-2:0], 1'b0};
                bit_cnt_q <= CNT_W'(1);
            end else if (!timeout_o) begin
                to_cnt_q <= to_cnt_q + 1'b1;
            end
        end else if (recv_i && rise_i) begin
            sr_o      <= {sr_o[LONG_W-2:0], cmd_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (in_window) begin
                crc_o <= crc7_step(crc_o, cmd_i);
            end
        end
    end

    assert_to_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        to_cnt_q < TO_W'(TIMEOUT_RISES));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_RISES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_rise,
    input  logic        clk_fall,
    input  logic        cmd_start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic [2:0]  rsp_mode,
    input  logic        err_clr,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    input  logic        dat0_in,
    output logic        cmd_done,
    output logic        err_timeout,
    output logic        err_crc,
    output logic [31:0] rsp_w0,
    output logic [31:0] rsp_w1,
    output logic [31:0] rsp_w2,
    output logic [31:0] rsp_w3
);

    eng_state_e state_q, state_d;
    rsp_mode_e  mode_q;

    logic               tx_load, tx_sent_all;
    logic [FRAME_W-1:0] tx_frame;
    logic [BODY_W-1:0]  tx_body;
    logic               rx_arm, rx_start, rx_timeout, rx_last;
    logic [LONG_W-1:0]  rx_sr;
    logic [6:0]         rx_crc;
    logic               is_long, crc_on, needs_rsp, frame_bad, crc_bad, rsp_bad;

    assign is_long   = (mode_q == RSP_LONG);
    assign crc_on    = (mode_q == RSP_SHORT) || (mode_q == RSP_LONG) || (mode_q == RSP_SHORT_BUSY);
    assign needs_rsp = crc_on || (mode_q == RSP_SHORT_NOCRC);

    assign tx_body  = {2'b01, cmd_index, cmd_arg};
    assign tx_frame = {tx_body, crc7_body(tx_body), 1'b1};
    assign tx_load  = (state_q == S_IDLE) && cmd_start;
    assign rx_arm   = (state_q == S_SEND) && clk_fall && tx_sent_all;

    assign frame_bad = is_long ? (rx_sr[LONG_W-2] || !rx_sr[0])
                               : (rx_sr[SHORT_W-2] || !rx_sr[0]);
    assign crc_bad   = crc_on && (rx_sr[7:1] != rx_crc);
    assign rsp_bad   = frame_bad || crc_bad;

    sdcmd_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tx_load),
        .frame_i    (tx_frame),
        .active_i   (state_q == S_SEND),
        .fall_i     (clk_fall),
        .cmd_out_o  (cmd_out),
        .cmd_oe_o   (cmd_oe),
        .sent_all_o (tx_sent_all)
    );

    sdcmd_rx #(.TIMEOUT_RISES(TIMEOUT_RISES)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (rx_arm),
        .wait_i       (state_q == S_WAIT),
        .recv_i       (state_q == S_RECV),
        .rise_i       (clk_rise),
        .cmd_i        (cmd_in),
        .long_i       (is_long),
        .start_seen_o (rx_start),
        .timeout_o    (rx_timeout),
        .last_bit_o   (rx_last),
        .sr_o         (rx_sr),
        .crc_o        (rx_crc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_start) state_d = S_SEND;
            S_SEND:  if (clk_fall && tx_sent_all) state_d = needs_rsp ? S_WAIT : S_DONE;
            S_WAIT:  begin
                if (rx_start)        state_d = S_RECV;
                else if (rx_timeout) state_d = S_FAIL;
            end
            S_RECV:  if (rx_last) state_d = S_CHECK;
            S_CHECK: begin
                if (rsp_bad)                       state_d = S_FAIL;
                else if (mode_q == RSP_SHORT_BUSY) state_d = S_BUSY;
                else                               state_d = S_DONE;
            end
            S_BUSY:  if (clk_rise && dat0_in) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_FAIL:  state_d = S_HALT;
            S_HALT:  if (err_clr) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= RSP_NONE;
            err_timeout <= 1'b0;
            err_crc     <= 1'b0;
            rsp_w0      <= '0;
            rsp_w1      <= '0;
            rsp_w2      <= '0;
            rsp_w3      <= '0;
        end else begin
            if (tx_load) begin
                mode_q <= (rsp_mode > 3'd4) ? RSP_NONE : rsp_mode_e'(rsp_mode);
            end
            if (state_q == S_WAIT && state_d == S_FAIL) err_timeout <= 1'b1;
            if (state_q == S_CHECK && state_d == S_FAIL) err_crc <= 1'b1;
            if (state_q == S_HALT && err_clr) begin
                err_timeout <= 1'b0;
                err_crc     <= 1'b0;
            end
            if (state_q == S_CHECK && !rsp_bad) begin
                if (is_long) begin
                    {rsp_w0, rsp_w1, rsp_w2, rsp_w3} <= rx_sr[127:0];
                end else begin
                    rsp_w0 <= rx_sr[39:8];
                    rsp_w1 <= '0;
                    rsp_w2 <= '0;
                    rsp_w3 <= '0;
                end
            end
        end
    end

    always_comb begin
        cmd_done = (state_q == S_DONE) || (state_q == S_FAIL);
    end

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_timeout, err_crc}));

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_timeout) || $rose(err_crc)) |-> cmd_done);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && !(clk_rise && dat0_in)) |=> (state_q != S_DONE));

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && !err_clr) |=> (state_q == S_HALT && !cmd_oe));

endmodule

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_rise = 1'b0, clk_fall = 1'b0;
    logic        cmd_start = 1'b0, err_clr = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [2:0]  rsp_mode = '0;
    logic        cmd_in = 1'b1, dat0_in = 1'b1;
    logic        cmd_out, cmd_oe, cmd_done, err_timeout, err_crc;
    logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;

    int checks = 0, fails = 0;
    int cyc = 0, done_cnt = 0, done_cyc = 0, rel_cyc = 0, r2_viol = 0;
    logic last_to, last_crc, prev_out = 1'b1;
    logic [47:0] got_frame;

    sdcmd_engine uut (
        .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .clk_fall(clk_fall),
        .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .rsp_mode(rsp_mode), .err_clr(err_clr), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .dat0_in(dat0_in),
        .cmd_done(cmd_done), .err_timeout(err_timeout), .err_crc(err_crc),
        .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3)
    );

    initial forever #10 clk = ~clk;

    // card clock strobes: one rise and one fall per four system cycles
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            clk_rise = (ph == 1);
            clk_fall = (ph == 3);
        end
    end

    // completion and drive-timing monitor
    initial forever begin
        @(posedge clk);
        #2;
        cyc++;
        if (cmd_done) begin
            done_cnt++;
            done_cyc = cyc;
            last_to  = err_timeout;
            last_crc = err_crc;
        end
        if (rst_n && cmd_out !== prev_out && !clk_fall) r2_viol++;
        prev_out = cmd_out;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_ref(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c;
        logic fb;
        c = 7'd0;
        for (int i = hi; i >= lo; i--) begin
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] op, input logic [31:0] arg);
        logic [135:0] v;
        v = '0;
        v[39:0] = {2'b01, op, arg};
        return {v[39:0], crc_ref(v, 39, 0), 1'b1};
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] st);
        logic [135:0] v;
        v = '0;
        v[39:0] = {2'b00, idx, st};
        return {88'd0, v[39:0], crc_ref(v, 39, 0), 1'b1};
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] body);
        logic [135:0] v;
        v = {8'h3F, body, 8'h00};
        v[7:0] = {crc_ref(v, 127, 8), 1'b1};
        return v;
    endfunction

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic run_cmd(input logic [5:0] op, input logic [31:0] arg, input logic [2:0] mode,
                           input int delay, input int rlen, input logic [135:0] rbits, input int busy);
        int d0, nb, r, lim;
        d0 = done_cnt;
        tick();
        cmd_index = op; cmd_arg = arg; rsp_mode = mode; cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
        nb = 0; lim = 0; got_frame = '0;
        while (nb < 48 && lim < 2000) begin
            tick(); lim++;
            if (clk_rise && cmd_oe && (nb > 0 || cmd_out == 1'b0)) begin
                got_frame = {got_frame[46:0], cmd_out};
                nb++;
            end
        end
        lim = 0;
        while (cmd_oe && lim < 100) begin tick(); lim++; end
        if (rlen > 0) begin
            r = 0;
            while (r <= delay + rlen + busy) begin
                tick();
                if (clk_rise) begin
                    if (r >= delay && r < delay + rlen) cmd_in = rbits[rlen - 1 - (r - delay)];
                    else cmd_in = 1'b1;
                    if (busy > 0 && r >= delay && r < delay + rlen + busy) dat0_in = 1'b0;
                    else begin
                        if (dat0_in == 1'b0) rel_cyc = cyc;
                        dat0_in = 1'b1;
                    end
                    r++;
                end
            end
        end
        lim = 0;
        while (done_cnt == d0 && lim < 3000) begin tick(); lim++; end
        repeat (3) tick();
    endtask

    task automatic clear_err;
        tick(); err_clr = 1'b1;
        tick(); err_clr = 1'b0;
        tick();
    endtask

    initial begin
        logic [135:0] rb;
        logic [119:0] body;
        int oe_seen;
        void'($urandom(32'h5D1C0DE));
        repeat (5) tick();
        // reset state (R2, R10)
        check(cmd_oe == 1'b0 && cmd_out == 1'b1 && cmd_done == 1'b0 && !err_timeout && !err_crc,
              "R2 R10 reset", {cmd_oe, cmd_out, cmd_done, err_timeout, err_crc}, 5'b01000);
        rst_n = 1'b1;
        repeat (4) tick();

        // R1 R3: known frame, no response
        run_cmd(6'd0, 32'd0, 3'd0, 0, 0, '0, 0);
        check(got_frame == 48'h400000000095, "R1 frame idx0", got_frame, 48'h400000000095);
        check(done_cnt == 1 && !last_to && !last_crc, "R3 none done", {done_cnt, last_to, last_crc}, {32'd1, 2'b00});

        // R3: code 7 acts as no response
        run_cmd(6'd17, 32'd0, 3'd7, 0, 0, '0, 0);
        check(got_frame == 48'h510000000055, "R1 frame idx17", got_frame, 48'h510000000055);
        check(done_cnt == 2 && !err_timeout && !err_crc, "R3 code7 done", {done_cnt, err_timeout, err_crc}, {32'd2, 2'b00});

        // R4: short response words
        run_cmd(6'd13, 32'hDEAD_BEEF, 3'd1, 5, 48, mk_short(6'd13, 32'h1234_5678), 0);
        check(got_frame == exp_frame(6'd13, 32'hDEAD_BEEF), "R1 frame arg", got_frame, exp_frame(6'd13, 32'hDEAD_BEEF));
        check({rsp_w0, rsp_w1, rsp_w2, rsp_w3} == {32'h1234_5678, 96'd0} && !err_crc,
              "R4 short words", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, {32'h1234_5678, 96'd0});

        // R5: long response words
        body = {32'hA5A5_0F0F, 32'h0123_4567, 32'h89AB_CDEF, 24'hC0FFEE};
        rb = mk_long(body);
        run_cmd(6'd2, 32'd0, 3'd3, 2, 136, rb, 0);
        check({rsp_w0, rsp_w1, rsp_w2, rsp_w3} == rb[127:0] && !err_crc,
              "R5 long words", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, rb[127:0]);

        // R6: bad CRC in checked mode
        rb = mk_short(6'd7, 32'hCAFE_0001);
        rb[3] = ~rb[3];
        run_cmd(6'd7, 32'h0, 3'd1, 3, 48, rb, 0);
        check(last_crc && !last_to, "R6 crc err", {last_crc, last_to}, 2'b10);

        // R11: start ignored while halted
        oe_seen = 0;
        tick(); cmd_start = 1'b1; tick(); cmd_start = 1'b0;
        repeat (40) begin tick(); if (cmd_oe) oe_seen++; end
        check(oe_seen == 0 && err_crc, "R11 start ignored", {oe_seen, err_crc}, {32'd0, 1'b1});
        // R11: clear and start in the same cycle
        tick(); err_clr = 1'b1; cmd_start = 1'b1;
        tick(); err_clr = 1'b0; cmd_start = 1'b0;
        repeat (40) begin tick(); if (cmd_oe) oe_seen++; end
        check(oe_seen == 0 && !err_crc && !err_timeout, "R11 clear with start",
              {oe_seen, err_crc, err_timeout}, {32'd0, 2'b00});

        // R6: CRC ignored in mode 2
        run_cmd(6'd41, 32'h00FF_8000, 3'd2, 1, 48, rb, 0);
        check(!err_crc && rsp_w0 == 32'hCAFE_0001, "R6 crc ignored", {err_crc, rsp_w0}, {1'b0, 32'hCAFE_0001});

        // R7: end bit 0 in mode 2
        rb = mk_short(6'd41, 32'h5555_AAAA);
        rb[0] = 1'b0;
        run_cmd(6'd41, 32'h1, 3'd2, 1, 48, rb, 0);
        check(last_crc, "R7 end bit", last_crc, 1'b1);
        clear_err();
        // R7: transmission bit 1
        rb = mk_short(6'd41, 32'h5555_AAAA);
        rb[46] = 1'b1;
        run_cmd(6'd41, 32'h1, 3'd2, 1, 48, rb, 0);
        check(last_crc, "R7 transmission bit", last_crc, 1'b1);
        clear_err();

        // R8: start bit on the 64th rise is accepted
        run_cmd(6'd9, 32'h4242, 3'd1, 63, 48, mk_short(6'd9, 32'h0BAD_F00D), 0);
        check(!err_timeout && !err_crc && rsp_w0 == 32'h0BAD_F00D, "R8 last rise ok",
              {err_timeout, err_crc, rsp_w0}, {2'b00, 32'h0BAD_F00D});
        // R8 R10: one rise later is a timeout
        run_cmd(6'd9, 32'h4242, 3'd1, 64, 48, mk_short(6'd9, 32'h1), 0);
        check(last_to && !last_crc && rsp_w0 == 32'h0BAD_F00D, "R8 R10 timeout",
              {last_to, last_crc, rsp_w0}, {2'b10, 32'h0BAD_F00D});
        clear_err();

        // R9: busy wait
        run_cmd(6'd12, 32'h0, 3'd4, 4, 48, mk_short(6'd12, 32'h0000_0900), 12);
        check(done_cyc > rel_cyc && rel_cyc > 0 && !err_crc, "R9 busy release",
              {done_cyc, rel_cyc}, {rel_cyc + 1, rel_cyc});

        // constrained random mix
        for (int k = 0; k < 10; k++) begin
            logic [5:0]  op;
            logic [31:0] arg, st;
            logic [2:0]  md;
            int dl, bz;
            op  = 6'($urandom);
            arg = $urandom;
            st  = $urandom;
            md  = 3'($urandom_range(1, 4));
            dl  = $urandom_range(0, 40);
            bz  = (md == 3'd4) ? $urandom_range(0, 6) : 0;
            if (md == 3'd3) begin
                body = {$urandom, $urandom, $urandom, 24'($urandom)};
                rb = mk_long(body);
                run_cmd(op, arg, md, dl, 136, rb, bz);
                check(got_frame == exp_frame(op, arg) && {rsp_w0, rsp_w1, rsp_w2, rsp_w3} == rb[127:0] && !err_crc && !err_timeout,
                      "R1 R5 random long", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, rb[127:0]);
            end else begin
                rb = mk_short(op, st);
                run_cmd(op, arg, md, dl, 48, rb, bz);
                check(got_frame == exp_frame(op, arg) && {rsp_w0, rsp_w1, rsp_w2, rsp_w3} == {st, 96'd0} && !err_crc && !err_timeout,
                      "R1 R4 random short", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, {st, 96'd0});
            end
        end

        check(r2_viol == 0, "R2 drive on fall only", r2_viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule